// File: doc/BRIEF.md
# Control Register Move Unit

This block serves the move-to and move-from control register path of a processor core, for a family of five CPU variants (V0 oldest to V4 newest). Each request names a 12-bit register code, a direction and 32 bits of write data. The block decides whether the code is legal for the current variant. A legal write stores the data through a per-variant writable-bit mask. A legal read returns the stored value, and for the cache-control register it also applies a separate per-variant read mask. An illegal code produces an illegal-instruction indication, reports the direction of the access, and leaves all state as it was.

The block also keeps the live stack pointer. The master and interrupt stack registers alias that pointer, and a mode bit decides which of the two is the active one. The core can load the live pointer directly. Effects on caches and on address translation are outside this block. They show up only as one-cycle notify strobes that come out with the response.

Top module: `ctlreg_unit`

## Requirements
- R1: Each request accepted on a clock edge produces exactly one response on the following cycle: `rsp_valid_o` is high for one cycle, and `rsp_write_o` echoes the request's direction. With no request, `rsp_valid_o` is low.
- R2: Legal codes per variant. V0: 0x000, 0x001, 0x800, 0x801. V1 and V2: 0x000–0x002 and 0x800–0x804. V3: 0x000–0x007 and 0x800–0x807, but not 0x802. V4: 0x000–0x008, 0x800, 0x801 and 0x806–0x808. Every other code, and every access under variant encodings 5–7, raises `rsp_illegal_o` together with `rsp_valid_o`.
- R3: An illegal access changes no stored register and does not change the live stack pointer.
- R4: Writes to codes 0x000 and 0x001 keep only bits 2:0.
- R5: Code 0x002 has these write masks: 0x0000000F (V1), 0x00003F1F (V2), 0x80008000 (V3), 0xF8E0E000 (V4). It has these read masks: 0x00000003, 0x00003313, 0x80008000, 0xF880E000.
- R6: Code 0x003 stores data AND 0xFFFE on V4 and data AND 0xC000 on V3. Codes 0x004–0x007 store data AND 0xFFFFE364.
- R7: Code 0x008 keeps bits 31:28 only. Codes 0x806 and 0x807 clear bits 8:0 on V4 and keep all bits on other variants. Codes 0x800, 0x801, 0x802 and 0x805 keep all bits.
- R8: A write to 0x803 while `mode_m_i` is 1, or to 0x804 while `mode_m_i` is 0, also loads the live stack pointer. The other combinations leave the live pointer alone.
- R9: A read of 0x803 while `mode_m_i` is 1, or of 0x804 while `mode_m_i` is 0, returns the live stack pointer. Otherwise the read returns the stored register.
- R10: A write to 0x808 updates only bits 6, 1 and 0. Bit 1 is forced to 1 when `fpu_present_i` is 0. `icache_flush_o` pulses with the response exactly when bit 1 changed.
- R11: A legal write to 0x002 pulses `cache_upd_o`. A legal write to 0x003–0x007 pulses `mmu_upd_o`. Each pulse lasts one cycle and comes with the response.
- R12: After reset all registers and the live stack pointer read zero. The variant selector is captured only on cycles without a request, so a change that arrives together with a request does not affect that request.
- R13: `sp_set_i` loads the live stack pointer with `sp_set_val_i`. When it coincides with a legal write that loads the pointer (R8), the request's data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_i | input | 3 | CPU variant selector, 0..4 valid |
| fpu_present_i | input | 1 | Floating-point unit present |
| mode_m_i | input | 1 | Stack mode bit: 1 selects master stack as active |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write register, 0 = read register |
| req_code_i | input | 12 | Control register code |
| req_wdata_i | input | 32 | Write data |
| sp_set_i | input | 1 | Load live stack pointer from core |
| sp_set_val_i | input | 32 | Value for live stack pointer load |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_illegal_o | output | 1 | Request code illegal for the variant |
| rsp_write_o | output | 1 | Direction of the responded request |
| rsp_rdata_o | output | 32 | Read data (zero on writes and illegal accesses) |
| sp_live_o | output | 32 | Live stack pointer |
| icache_flush_o | output | 1 | Instruction cache flush strobe |
| cache_upd_o | output | 1 | Cache control updated strobe |
| mmu_upd_o | output | 1 | Translation register updated strobe |

## Verification
The legality decode is swept across all eight variant encodings with every defined code and with a few undefined neighbours (0x009, 0x80A, 0x400, 0xFFF). This separates a too-wide range from a missing exception such as 0x802 on V3. The masks are probed by writing all ones and then reading back, so each variant's cache-control pair (write mask combined with read mask) and each translation mask gets a distinct value. Stack aliasing is tried with the mode bit both set and clear, after the live pointer has diverged from the stored registers, so an alias read can be told apart from a stored read. The configuration register is written with the FPU present and absent to tell a real bit-1 change from a forced one.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int DATA_W  = 32;
    localparam int CODE_W  = 12;
    localparam int VAR_W   = 3;
    localparam int BANK_N  = 9;                 // codes per bank
    localparam int NREG    = 2 * BANK_N;
    localparam int SLOT_W  = $clog2(NREG);

    typedef enum logic [VAR_W-1:0] {
        VAR_0 = 3'd0,
        VAR_1 = 3'd1,
        VAR_2 = 3'd2,
        VAR_3 = 3'd3,
        VAR_4 = 3'd4
    } variant_e;

    localparam logic [DATA_W-1:0] CFG_BITS    = 32'h0000_0043;
    localparam int                CFG_FPU_BIT = 1;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]           sp_live;
        logic [VAR_W-1:0]            var_sel;
        logic                        rsp_valid;
        logic                        rsp_illegal;
        logic                        rsp_write;
        logic [DATA_W-1:0]           rdata;
        logic                        flush;
        logic                        cache_upd;
        logic                        mmu_upd;
    } state_t;
endpackage

// File: rtl/ctlreg_legal.sv
module ctlreg_legal
    import ctlreg_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [VAR_W-1:0]  var_i,
    output logic              legal_o,
    output logic              hi_o,
    output logic [3:0]        sel_o
);
    logic in_lo, in_hi;
    logic [3:0] sel;

    always_comb begin
        sel   = code_i[3:0];
        in_lo = (code_i[CODE_W-1:4] == 8'h00) && (sel < 4'(BANK_N));
        in_hi = (code_i[CODE_W-1:4] == 8'h80) && (sel < 4'(BANK_N));
        legal_o = 1'b0;
        case (var_i)
            VAR_0: legal_o = (in_lo || in_hi) && (sel <= 4'd1);
            VAR_1,
            VAR_2: legal_o = (in_lo && sel <= 4'd2) || (in_hi && sel <= 4'd4);
            VAR_3: legal_o = (in_lo && sel <= 4'd7) || (in_hi && sel <= 4'd7 && sel != 4'd2);
            VAR_4: legal_o = in_lo || (in_hi && (sel <= 4'd1 || sel >= 4'd6));
            default: legal_o = 1'b0;
        endcase
        hi_o  = code_i[CODE_W-1];
        sel_o = sel;
    end
endmodule

// File: rtl/ctlreg_mask.sv
module ctlreg_mask
    import ctlreg_pkg::*;
(
    input  logic              hi_i,
    input  logic [3:0]        sel_i,
    input  logic [VAR_W-1:0]  var_i,
    output logic [DATA_W-1:0] wmask_o,
    output logic [DATA_W-1:0] rmask_o
);
    logic is_v4;

    always_comb begin
        is_v4   = (var_i == VAR_4);
        wmask_o = '1;
        rmask_o = '1;
        if (!hi_i) begin
            case (sel_i)
                4'd0, 4'd1: wmask_o = 32'h0000_0007;
                4'd2: begin
                    case (var_i)
                        VAR_1:   begin wmask_o = 32'h0000_000F; rmask_o = 32'h0000_0003; end
                        VAR_2:   begin wmask_o = 32'h0000_3F1F; rmask_o = 32'h0000_3313; end
                        VAR_3:   begin wmask_o = 32'h8000_8000; rmask_o = 32'h8000_8000; end
                        VAR_4:   begin wmask_o = 32'hF8E0_E000; rmask_o = 32'hF880_E000; end
                        default: begin wmask_o = '0;            rmask_o = '0;            end
                    endcase
                end
                4'd3: wmask_o = is_v4 ? 32'h0000_FFFE : 32'h0000_C000;
                4'd4, 4'd5, 4'd6, 4'd7: wmask_o = 32'hFFFF_E364;
                4'd8: wmask_o = 32'hF000_0000;
                default: wmask_o = '0;
            endcase
        end else begin
            case (sel_i)
                4'd6, 4'd7: wmask_o = is_v4 ? 32'hFFFF_FE00 : 32'hFFFF_FFFF;
                4'd8:       wmask_o = CFG_BITS;
                default:    wmask_o = '1;
            endcase
        end
    end
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        variant_i,
    input  logic              fpu_present_i,
    input  logic              mode_m_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [11:0]       req_code_i,
    input  logic [31:0]       req_wdata_i,
    input  logic              sp_set_i,
    input  logic [31:0]       sp_set_val_i,
    output logic              rsp_valid_o,
    output logic              rsp_illegal_o,
    output logic              rsp_write_o,
    output logic [31:0]       rsp_rdata_o,
    output logic [31:0]       sp_live_o,
    output logic              icache_flush_o,
    output logic              cache_upd_o,
    output logic              mmu_upd_o
);
    state_t state_d, state_q;

    logic              legal;
    logic              hi;
    logic [3:0]        sel;
    logic [DATA_W-1:0] wmask, rmask;
    logic [SLOT_W-1:0] slot;
    logic              is_msp, is_isp, is_cfg;
    logic [DATA_W-1:0] newval;

    ctlreg_legal u_legal (
        .code_i  (req_code_i),
        .var_i   (state_q.var_sel),
        .legal_o (legal),
        .hi_o    (hi),
        .sel_o   (sel)
    );

    ctlreg_mask u_mask (
        .hi_i    (hi),
        .sel_i   (sel),
        .var_i   (state_q.var_sel),
        .wmask_o (wmask),
        .rmask_o (rmask)
    );

    always_comb begin
        state_d             = state_q;
        state_d.rsp_valid   = req_valid_i;
        state_d.rsp_write   = req_valid_i & req_write_i;
        state_d.rsp_illegal = 1'b0;
        state_d.rdata       = '0;
        state_d.flush       = 1'b0;
        state_d.cache_upd   = 1'b0;
        state_d.mmu_upd     = 1'b0;

        slot   = hi ? SLOT_W'(BANK_N + int'(sel)) : SLOT_W'(sel);
        is_msp = hi && (sel == 4'd3);
        is_isp = hi && (sel == 4'd4);
        is_cfg = hi && (sel == 4'd8);
        newval = req_wdata_i & wmask;

        if (!req_valid_i)
            state_d.var_sel = variant_i;
        if (sp_set_i)
            state_d.sp_live = sp_set_val_i;

        if (req_valid_i) begin
            if (!legal) begin
                state_d.rsp_illegal = 1'b1;
            end else if (req_write_i) begin
                if (is_cfg) begin
                    newval = (state_q.regs[slot] & ~CFG_BITS) | (req_wdata_i & CFG_BITS);
                    if (!fpu_present_i)
                        newval[CFG_FPU_BIT] = 1'b1;
                    state_d.flush = newval[CFG_FPU_BIT] ^ state_q.regs[slot][CFG_FPU_BIT];
                end
                state_d.regs[slot] = newval;
                if ((is_msp && mode_m_i) || (is_isp && !mode_m_i))
                    state_d.sp_live = req_wdata_i;
                state_d.cache_upd = !hi && (sel == 4'd2);
                state_d.mmu_upd   = !hi && (sel >= 4'd3) && (sel <= 4'd7);
            end else begin
                if ((is_msp && mode_m_i) || (is_isp && !mode_m_i))
                    state_d.rdata = state_q.sp_live;
                else
                    state_d.rdata = state_q.regs[slot] & rmask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rsp_valid_o    = state_q.rsp_valid;
    assign rsp_illegal_o  = state_q.rsp_illegal;
    assign rsp_write_o    = state_q.rsp_write;
    assign rsp_rdata_o    = state_q.rdata;
    assign sp_live_o      = state_q.sp_live;
    assign icache_flush_o = state_q.flush;
    assign cache_upd_o    = state_q.cache_upd;
    assign mmu_upd_o      = state_q.mmu_upd;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    assert_illegal_is_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal_o |-> rsp_valid_o);
    assert_illegal_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal_o && !$past(sp_set_i)) |-> ($stable(sp_live_o) && $stable(state_q.regs)));
    assert_strobe_on_legal_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (icache_flush_o || cache_upd_o || mmu_upd_o) |-> (rsp_valid_o && rsp_write_o && !rsp_illegal_o));
    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({icache_flush_o, cache_upd_o, mmu_upd_o}));
    assert_variant_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> $stable(state_q.var_sel));
endmodule

// File: tb/sim_ctlreg_unit.sv
`timescale 1ns/1ps
module sim_ctlreg_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  variant;
    logic        fpu_present, mode_m;
    logic        req_valid, req_write;
    logic [11:0] req_code;
    logic [31:0] req_wdata;
    logic        sp_set;
    logic [31:0] sp_set_val;
    logic        rsp_valid, rsp_illegal, rsp_write;
    logic [31:0] rsp_rdata, sp_live;
    logic        flush, cache_upd, mmu_upd;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ctlreg_unit u0 (
        .clk(clk), .rst_n(rst_n), .variant_i(variant), .fpu_present_i(fpu_present),
        .mode_m_i(mode_m), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_code_i(req_code), .req_wdata_i(req_wdata), .sp_set_i(sp_set),
        .sp_set_val_i(sp_set_val), .rsp_valid_o(rsp_valid), .rsp_illegal_o(rsp_illegal),
        .rsp_write_o(rsp_write), .rsp_rdata_o(rsp_rdata), .sp_live_o(sp_live),
        .icache_flush_o(flush), .cache_upd_o(cache_upd), .mmu_upd_o(mmu_upd)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one request; leaves outputs sampled at the following negedge
    task automatic access(input logic wr, input logic [11:0] code, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_code = code; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 valid", 32'(rsp_valid), 32'd1);
        chk("R1 dir", 32'(rsp_write), 32'(wr));
    endtask

    task automatic set_variant(input logic [2:0] v);
        @(negedge clk);
        variant = v;
        @(negedge clk);
    endtask

    task automatic wr_rd(input string req, input logic [11:0] code, input logic [31:0] wd,
                         input logic [31:0] exp);
        access(1'b1, code, wd);
        chk({req, " write legal"}, 32'(rsp_illegal), 32'd0);
        access(1'b0, code, 32'h0);
        chk(req, rsp_rdata, exp);
    endtask

    function automatic logic exp_legal(input int v, input int code);
        case (code)
            'h000, 'h001, 'h800, 'h801: return v <= 4;
            'h002:                      return v >= 1 && v <= 4;
            'h802:                      return v == 1 || v == 2;
            'h803, 'h804:               return v >= 1 && v <= 3;
            'h003, 'h004, 'h005, 'h006, 'h007: return v == 3 || v == 4;
            'h805:                      return v == 3;
            'h806, 'h807:               return v == 3 || v == 4;
            'h008, 'h808:               return v == 4;
            default:                    return 1'b0;
        endcase
    endfunction

    task automatic t_reset;
        chk("R12 reset valid", 32'(rsp_valid), 32'd0);
        chk("R12 reset sp", sp_live, 32'd0);
        set_variant(3'd4);
        access(1'b0, 12'h801, 32'h0);
        chk("R12 reset reg", rsp_rdata, 32'd0);
        access(1'b0, 12'h807, 32'h0);
        chk("R12 reset reg", rsp_rdata, 32'd0);
    endtask

    task automatic t_latency;
        set_variant(3'd0);
        access(1'b1, 12'h801, 32'h1);
        @(negedge clk);
        chk("R1 single cycle", 32'(rsp_valid), 32'd0);
        access(1'b0, 12'h801, 32'h0);
        chk("R1 read data", rsp_rdata, 32'h1);
    endtask

    task automatic t_legal_sweep;
        int codes[22] = '{'h000,'h001,'h002,'h003,'h004,'h005,'h006,'h007,'h008,
                          'h800,'h801,'h802,'h803,'h804,'h805,'h806,'h807,'h808,
                          'h009,'h80A,'h400,'hFFF};
        for (int v = 0; v < 8; v++) begin
            set_variant(3'(v));
            for (int i = 0; i < 22; i++) begin
                access(1'b0, 12'(codes[i]), 32'h0);
                chk($sformatf("R2 v%0d code %h", v, codes[i]), 32'(rsp_illegal),
                    32'(!exp_legal(v, codes[i])));
            end
        end
    endtask

    task automatic t_illegal_state;
        set_variant(3'd1);
        wr_rd("R3 setup", 12'h802, 32'h1111_2222, 32'h1111_2222);
        set_variant(3'd0);
        access(1'b1, 12'h802, 32'hDEAD_BEEF);
        chk("R3 illegal flagged", 32'(rsp_illegal), 32'd1);
        chk("R3 no strobe", 32'({flush, cache_upd, mmu_upd}), 32'd0);
        set_variant(3'd1);
        access(1'b0, 12'h802, 32'h0);
        chk("R3 reg unchanged", rsp_rdata, 32'h1111_2222);
        mode_m = 1'b1;
        access(1'b1, 12'h803, 32'h0BAD_0BAD);
        chk("R3 setup sp", sp_live, 32'h0BAD_0BAD);
        set_variant(3'd4);
        access(1'b1, 12'h803, 32'h7777_7777);
        chk("R3 illegal flagged", 32'(rsp_illegal), 32'd1);
        chk("R3 sp unchanged", sp_live, 32'h0BAD_0BAD);
        mode_m = 1'b0;
    endtask

    task automatic t_fc;
        set_variant(3'd2);
        wr_rd("R4 sfc", 12'h000, 32'hFFFF_FFFF, 32'h7);
        wr_rd("R4 dfc", 12'h001, 32'hA5A5_A5AD, 32'h5);
    endtask

    task automatic t_cacr;
        logic [31:0] exp[5] = '{32'h0, 32'h3, 32'h3313, 32'h8000_8000, 32'hF880_E000};
        for (int v = 1; v <= 4; v++) begin
            set_variant(3'(v));
            access(1'b1, 12'h002, 32'hFFFF_FFFF);
            chk("R11 cache strobe", 32'(cache_upd), 32'd1);
            chk("R11 no mmu strobe", 32'(mmu_upd), 32'd0);
            access(1'b0, 12'h002, 32'h0);
            chk($sformatf("R5 cacr v%0d", v), rsp_rdata, exp[v]);
        end
        set_variant(3'd2);
        wr_rd("R5 v2 partial", 12'h002, 32'h0000_0C0C, 32'h0000_0000);
    endtask

    task automatic t_mmu;
        set_variant(3'd3);
        access(1'b1, 12'h003, 32'hFFFF_FFFF);
        chk("R11 mmu strobe", 32'(mmu_upd), 32'd1);
        access(1'b0, 12'h003, 32'h0);
        chk("R6 tc v3", rsp_rdata, 32'h0000_C000);
        wr_rd("R6 tt v3", 12'h005, 32'hFFFF_FFFF, 32'hFFFF_E364);
        set_variant(3'd4);
        wr_rd("R6 tc v4", 12'h003, 32'hFFFF_FFFF, 32'h0000_FFFE);
        wr_rd("R6 tt v4", 12'h007, 32'hFFFF_FFFF, 32'hFFFF_E364);
        access(1'b1, 12'h008, 32'hFFFF_FFFF);
        chk("R11 no strobe bus", 32'({flush, cache_upd, mmu_upd}), 32'd0);
    endtask

    task automatic t_misc_mask;
        set_variant(3'd4);
        wr_rd("R7 bus", 12'h008, 32'hFFFF_FFFF, 32'hF000_0000);
        wr_rd("R7 urp v4", 12'h806, 32'hFFFF_FFFF, 32'hFFFF_FE00);
        wr_rd("R7 vbr", 12'h801, 32'h1234_5679, 32'h1234_5679);
        set_variant(3'd3);
        wr_rd("R7 srp v3", 12'h807, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr_rd("R7 mmusr v3", 12'h805, 32'h8765_4321, 32'h8765_4321);
    endtask

    task automatic t_stack;
        set_variant(3'd2);
        mode_m = 1'b1;
        access(1'b1, 12'h803, 32'h0000_1234);
        chk("R8 msp loads sp", sp_live, 32'h0000_1234);
        @(negedge clk); sp_set = 1'b1; sp_set_val = 32'h0000_5555;
        @(negedge clk); sp_set = 1'b0;
        chk("R13 sp_set", sp_live, 32'h0000_5555);
        access(1'b0, 12'h803, 32'h0);
        chk("R9 msp alias read", rsp_rdata, 32'h0000_5555);
        mode_m = 1'b0;
        access(1'b0, 12'h803, 32'h0);
        chk("R9 msp stored read", rsp_rdata, 32'h0000_1234);
        mode_m = 1'b1;
        access(1'b1, 12'h804, 32'h0000_AAAA);
        chk("R8 isp no load when M=1", sp_live, 32'h0000_5555);
        access(1'b0, 12'h804, 32'h0);
        chk("R9 isp stored read", rsp_rdata, 32'h0000_AAAA);
        mode_m = 1'b0;
        access(1'b0, 12'h804, 32'h0);
        chk("R9 isp alias read", rsp_rdata, 32'h0000_5555);
        access(1'b1, 12'h804, 32'h0000_BBBB);
        chk("R8 isp loads sp", sp_live, 32'h0000_BBBB);
        // simultaneous core load and stack write: request wins
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_code = 12'h804; req_wdata = 32'h0000_CCCC;
        sp_set = 1'b1; sp_set_val = 32'h0000_DDDD;
        @(negedge clk);
        req_valid = 1'b0; sp_set = 1'b0;
        chk("R13 request wins", sp_live, 32'h0000_CCCC);
    endtask

    task automatic t_cfg;
        set_variant(3'd4);
        fpu_present = 1'b1;
        access(1'b1, 12'h808, 32'hFFFF_FFFF);
        chk("R10 flush on change", 32'(flush), 32'd1);
        access(1'b0, 12'h808, 32'h0);
        chk("R10 cfg bits", rsp_rdata, 32'h0000_0043);
        access(1'b1, 12'h808, 32'h0000_0043);
        chk("R10 no flush same", 32'(flush), 32'd0);
        fpu_present = 1'b0;
        access(1'b1, 12'h808, 32'h0);
        chk("R10 no flush forced", 32'(flush), 32'd0);
        access(1'b0, 12'h808, 32'h0);
        chk("R10 forced bit", rsp_rdata, 32'h0000_0002);
        fpu_present = 1'b1;
        access(1'b1, 12'h808, 32'h0);
        chk("R10 flush on clear", 32'(flush), 32'd1);
        access(1'b0, 12'h808, 32'h0);
        chk("R10 cleared", rsp_rdata, 32'h0);
    endtask

    task automatic t_variant_sample;
        set_variant(3'd0);
        @(negedge clk);
        variant = 3'd4;
        req_valid = 1'b1; req_write = 1'b0; req_code = 12'h008; req_wdata = 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 old variant used", 32'(rsp_illegal), 32'd1);
        access(1'b0, 12'h008, 32'h0);
        chk("R12 new variant after idle", 32'(rsp_illegal), 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; variant = 3'd0; fpu_present = 1'b1; mode_m = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_code = '0; req_wdata = '0;
        sp_set = 1'b0; sp_set_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_legal_sweep;
        t_illegal_state;
        t_fc;
        t_cacr;
        t_mmu;
        t_misc_mask;
        t_stack;
        t_cfg;
        t_variant_sample;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule